// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits at the end of an Ethernet receive path and makes one decision per frame. When the receive logic reports that a frame has ended, it also supplies that frame's byte count, its error indications (CRC, alignment, code) and whether the frame is a MAC control frame or a pause frame. From these inputs the filter decides whether the frame goes to memory or is discarded. It also produces the status flags that travel with a kept frame. Separately, it raises a strobe that tells the flow-control logic to act on a valid pause frame.

Three copy enables control the filter. One lets control frames through, one lets frames under the minimum length through, and one lets errored frames through. A frame can belong to more than one of these categories, and it is kept only when every category it belongs to is enabled. The keep/drop verdict and the flags appear together as a single-cycle registered strobe. The pause strobe uses the same timing. It does not depend on whether the pause frame itself is kept.

Top module: `rx_frame_gate`

## Requirements
- R1: `verdict_valid` is high for exactly the one cycle after a cycle with `eof_valid` high. It is low in every other cycle. `keep` and all four footer flags are low whenever `verdict_valid` is low.
- R2: A frame counts as a control frame when `is_ctrl` or `is_pause` is 1. With `copy_ctrl_en` at 0 such a frame is dropped (`keep` = 0). With it at 1, and no other category blocking it, the frame is kept and `ftr_control` is 1.
- R3: A frame whose `frame_len` is below 64 bytes is a short frame. It is dropped when `copy_short_en` is 0.
- R4: A kept short frame that has any of `crc_err`, `align_err` or `code_err` set gets `ftr_fragment` = 1. A kept short frame with none of them gets `ftr_undersized` = 1. The two flags are never high together, and both are 0 for frames of 64 bytes or more and for dropped frames.
- R5: A frame with any of the three error inputs set is an errored frame. It is dropped when `copy_err_en` is 0. When it is kept, `ftr_error` is 1. `ftr_error` is 0 for frames without errors.
- R6: A frame is kept if and only if every category it falls in (control, short, errored) has its copy enable set. A frame in no category is always kept.
- R7: `pause_go` is high in the cycle after `eof_valid` if and only if, in that frame, `is_pause` = 1, all error inputs are 0, `frame_len` is at least 64, and `rx_flow_en` = 1. `copy_ctrl_en` has no effect on it.
- R8: `rst` is synchronous and active high. The cycle after a cycle with `rst` high, all outputs are 0, even if `eof_valid` was high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eof_valid | input | 1 | End-of-frame status is present this cycle |
| frame_len | input | LEN_W (16) | Received frame length in bytes |
| crc_err | input | 1 | Frame failed CRC check |
| align_err | input | 1 | Frame had an alignment error |
| code_err | input | 1 | Frame had a line code error |
| is_ctrl | input | 1 | Frame is a MAC control frame |
| is_pause | input | 1 | Frame is a pause frame (a control frame) |
| copy_ctrl_en | input | 1 | Keep control frames |
| copy_short_en | input | 1 | Keep frames shorter than the minimum |
| copy_err_en | input | 1 | Keep frames with errors |
| rx_flow_en | input | 1 | Receive flow control enabled |
| verdict_valid | output | 1 | Verdict and flags are valid this cycle |
| keep | output | 1 | Frame is written to memory |
| ftr_fragment | output | 1 | Kept short frame with an error |
| ftr_undersized | output | 1 | Kept short frame with no error |
| ftr_error | output | 1 | Kept frame with an error |
| ftr_control | output | 1 | Kept control frame |
| pause_go | output | 1 | Trigger the pause action |

## Verification
The filter's verdict and the pause trigger fire in the same cycle, so both need to be checked at that point. The key case is a pause frame that the filter drops while the flow-control logic must still act on it. The bench covers this by sweeping every combination of the error inputs, the frame-type inputs, the three copy enables and the flow enable, over lengths on both sides of the 64-byte boundary. In each frame it checks `keep` and `pause_go` independently in the cycle the strobe appears, so a dropped pause frame must still show `pause_go` = 1, and a kept pause frame with errors or a short length must show it at 0.

// File: rtl/rx_gate_pkg.sv
package rx_gate_pkg;

  // Categories a frame can fall in; each needs its copy enable to be kept.
  localparam int CAT_N    = 3;
  localparam int CAT_CTRL = 0;
  localparam int CAT_SMALL = 1;
  localparam int CAT_ERR  = 2;

  typedef logic [CAT_N-1:0] rx_cat_t;

  typedef struct packed {
    logic fragment;
    logic undersized;
    logic error;
    logic control;
  } rx_footer_t;

endpackage

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rx_gate_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic [LEN_W-1:0] frame_len,
  input  logic             crc_err,
  input  logic             align_err,
  input  logic             code_err,
  input  logic             is_ctrl,
  input  logic             is_pause,
  output rx_cat_t          cat,
  output logic             pause_ok
);

  localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

  logic small_f;
  logic err_f;
  logic ctrl_f;

  always_comb begin
    small_f = (frame_len < MIN_LEN_V);
    err_f   = crc_err | align_err | code_err;
    ctrl_f  = is_ctrl | is_pause;
    cat            = '0;
    cat[CAT_CTRL]  = ctrl_f;
    cat[CAT_SMALL] = small_f;
    cat[CAT_ERR]   = err_f;
    // Only a well-formed, full-length pause frame may stall the transmitter.
    pause_ok = is_pause & ~err_f & ~small_f;
  end

endmodule

// File: rtl/rx_keep_policy.sv
module rx_keep_policy
  import rx_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       eof_valid,
  input  rx_cat_t    cat,
  input  rx_cat_t    cat_en,
  output logic       verdict_valid,
  output logic       keep,
  output rx_footer_t footer
);

  rx_cat_t    cat_pass;
  logic       keep_d;
  rx_footer_t footer_d;

  // A category passes when the frame is not in it or when it is enabled.
  for (genvar g = 0; g < CAT_N; g++) begin : g_cat
    assign cat_pass[g] = ~cat[g] | cat_en[g];
  end

  always_comb begin
    keep_d              = eof_valid & (&cat_pass);
    footer_d.fragment   = keep_d & cat[CAT_SMALL] & cat[CAT_ERR];
    footer_d.undersized = keep_d & cat[CAT_SMALL] & ~cat[CAT_ERR];
    footer_d.error      = keep_d & cat[CAT_ERR];
    footer_d.control    = keep_d & cat[CAT_CTRL];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_valid <= 1'b0;
      keep          <= 1'b0;
      footer        <= '0;
    end else begin
      verdict_valid <= eof_valid;
      keep          <= keep_d;
      footer        <= footer_d;
    end
  end

endmodule

// File: rtl/rx_pause_trigger.sv
module rx_pause_trigger (
  input  logic clk,
  input  logic rst,
  input  logic eof_valid,
  input  logic pause_ok,
  input  logic rx_flow_en,
  output logic pause_go
);

  always_ff @(posedge clk) begin
    if (rst) pause_go <= 1'b0;
    else     pause_go <= eof_valid & pause_ok & rx_flow_en;
  end

endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate
  import rx_gate_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eof_valid,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             crc_err,
  input  logic             align_err,
  input  logic             code_err,
  input  logic             is_ctrl,
  input  logic             is_pause,
  input  logic             copy_ctrl_en,
  input  logic             copy_short_en,
  input  logic             copy_err_en,
  input  logic             rx_flow_en,
  output logic             verdict_valid,
  output logic             keep,
  output logic             ftr_fragment,
  output logic             ftr_undersized,
  output logic             ftr_error,
  output logic             ftr_control,
  output logic             pause_go
);

  rx_cat_t    cat;
  rx_cat_t    cat_en;
  logic       pause_ok;
  rx_footer_t footer;

  always_comb begin
    cat_en            = '0;
    cat_en[CAT_CTRL]  = copy_ctrl_en;
    cat_en[CAT_SMALL] = copy_short_en;
    cat_en[CAT_ERR]   = copy_err_en;
  end

  rx_frame_classifier #(
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN)
  ) u_class (
    .frame_len(frame_len),
    .crc_err  (crc_err),
    .align_err(align_err),
    .code_err (code_err),
    .is_ctrl  (is_ctrl),
    .is_pause (is_pause),
    .cat      (cat),
    .pause_ok (pause_ok)
  );

  rx_keep_policy u_policy (
    .clk          (clk),
    .rst          (rst),
    .eof_valid    (eof_valid),
    .cat          (cat),
    .cat_en       (cat_en),
    .verdict_valid(verdict_valid),
    .keep         (keep),
    .footer       (footer)
  );

  rx_pause_trigger u_pause (
    .clk       (clk),
    .rst       (rst),
    .eof_valid (eof_valid),
    .pause_ok  (pause_ok),
    .rx_flow_en(rx_flow_en),
    .pause_go  (pause_go)
  );

  assign ftr_fragment   = footer.fragment;
  assign ftr_undersized = footer.undersized;
  assign ftr_error      = footer.error;
  assign ftr_control    = footer.control;

endmodule

// File: rtl/rx_frame_gate_chk.sv
module rx_frame_gate_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             eof_valid,
  input logic [LEN_W-1:0] frame_len,
  input logic             crc_err,
  input logic             align_err,
  input logic             code_err,
  input logic             is_ctrl,
  input logic             is_pause,
  input logic             copy_ctrl_en,
  input logic             copy_short_en,
  input logic             copy_err_en,
  input logic             rx_flow_en,
  input logic             verdict_valid,
  input logic             keep,
  input logic             ftr_fragment,
  input logic             ftr_undersized,
  input logic             ftr_error,
  input logic             ftr_control,
  input logic             pause_go
);

  localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);

  assert_strobe_follows_eof_R1: assert property (@(posedge clk) disable iff (rst)
    eof_valid |=> verdict_valid);

  assert_no_spurious_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !eof_valid |=> !verdict_valid && !keep);

  assert_ctrl_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    eof_valid && (is_ctrl || is_pause) && !copy_ctrl_en |=> !keep && !ftr_control);

  assert_short_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    eof_valid && (frame_len < MIN_V) && !copy_short_en |=> !keep);

  assert_frag_undersized_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ftr_fragment, ftr_undersized}));

  assert_long_no_short_flags_R4: assert property (@(posedge clk) disable iff (rst)
    eof_valid && (frame_len >= MIN_V) |=> !ftr_fragment && !ftr_undersized);

  assert_err_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    eof_valid && (crc_err || align_err || code_err) && !copy_err_en |=> !keep);

  assert_plain_frame_kept_R6: assert property (@(posedge clk) disable iff (rst)
    eof_valid && !is_ctrl && !is_pause && (frame_len >= MIN_V) &&
    !crc_err && !align_err && !code_err |=> keep);

  assert_pause_fires_R7: assert property (@(posedge clk) disable iff (rst)
    eof_valid && is_pause && rx_flow_en && (frame_len >= MIN_V) &&
    !crc_err && !align_err && !code_err |=> pause_go);

  assert_pause_with_verdict_R7: assert property (@(posedge clk) disable iff (rst)
    pause_go |-> verdict_valid);

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> !verdict_valid && !keep && !pause_go);

endmodule

bind rx_frame_gate rx_frame_gate_chk #(
  .LEN_W  (LEN_W),
  .MIN_LEN(MIN_LEN)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .eof_valid     (eof_valid),
  .frame_len     (frame_len),
  .crc_err       (crc_err),
  .align_err     (align_err),
  .code_err      (code_err),
  .is_ctrl       (is_ctrl),
  .is_pause      (is_pause),
  .copy_ctrl_en  (copy_ctrl_en),
  .copy_short_en (copy_short_en),
  .copy_err_en   (copy_err_en),
  .rx_flow_en    (rx_flow_en),
  .verdict_valid (verdict_valid),
  .keep          (keep),
  .ftr_fragment  (ftr_fragment),
  .ftr_undersized(ftr_undersized),
  .ftr_error     (ftr_error),
  .ftr_control   (ftr_control),
  .pause_go      (pause_go)
);

// File: tb/test_rx_frame_gate.sv
`timescale 1ns/1ps
module test_rx_frame_gate;

  localparam int LEN_W   = 16;
  localparam int MIN_LEN = 64;
  localparam int NLEN    = 6;
  localparam int LENS [NLEN] = '{0, 1, 63, 64, 65, 1518};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eof_valid = 1'b0;
  logic [LEN_W-1:0] frame_len = '0;
  logic crc_err = 0, align_err = 0, code_err = 0, is_ctrl = 0, is_pause = 0;
  logic copy_ctrl_en = 0, copy_short_en = 0, copy_err_en = 0, rx_flow_en = 0;
  logic verdict_valid, keep, ftr_fragment, ftr_undersized, ftr_error, ftr_control, pause_go;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  rx_frame_gate #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_rx_frame_gate (
    .clk(clk), .rst(rst), .eof_valid(eof_valid), .frame_len(frame_len),
    .crc_err(crc_err), .align_err(align_err), .code_err(code_err),
    .is_ctrl(is_ctrl), .is_pause(is_pause), .copy_ctrl_en(copy_ctrl_en),
    .copy_short_en(copy_short_en), .copy_err_en(copy_err_en), .rx_flow_en(rx_flow_en),
    .verdict_valid(verdict_valid), .keep(keep), .ftr_fragment(ftr_fragment),
    .ftr_undersized(ftr_undersized), .ftr_error(ftr_error), .ftr_control(ftr_control),
    .pause_go(pause_go)
  );

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (len=%0d crc=%b al=%b cd=%b c=%b p=%b cc=%b cs=%b ce=%b fl=%b)",
               req, what, got, exp, frame_len, crc_err, align_err, code_err, is_ctrl, is_pause,
               copy_ctrl_en, copy_short_en, copy_err_en, rx_flow_en);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "verdict_valid idle", verdict_valid, 1'b0);
    check(req, "keep idle", keep, 1'b0);
    check(req, "pause_go idle", pause_go, 1'b0);
  endtask

  // One frame: drive at a falling edge, check the registered strobe one clock later.
  task automatic run_frame(input int len, input logic [8:0] v);
    logic small_e, err_e, ctrl_e, keep_e, pause_e;
    string keep_req;
    @(negedge clk);
    check("R1", "strobe low between frames", verdict_valid, 1'b0);
    frame_len     = LEN_W'(len);
    crc_err       = v[0];
    align_err     = v[1];
    code_err      = v[2];
    is_ctrl       = v[3];
    is_pause      = v[4];
    copy_ctrl_en  = v[5];
    copy_short_en = v[6];
    copy_err_en   = v[7];
    rx_flow_en    = v[8];
    eof_valid     = 1'b1;
    small_e = (len < MIN_LEN);
    err_e   = v[0] | v[1] | v[2];
    ctrl_e  = v[3] | v[4];
    keep_e  = !(ctrl_e && !v[5]) && !(small_e && !v[6]) && !(err_e && !v[7]);
    pause_e = v[4] && !err_e && !small_e && v[8];
    if (ctrl_e && !small_e && !err_e)      keep_req = "R2";
    else if (small_e && !ctrl_e && !err_e) keep_req = "R3";
    else if (err_e && !ctrl_e && !small_e) keep_req = "R5";
    else                                   keep_req = "R6";
    @(negedge clk);
    eof_valid = 1'b0;
    check("R1", "verdict_valid", verdict_valid, 1'b1);
    check(keep_req, "keep", keep, keep_e);
    check("R4", "ftr_fragment", ftr_fragment, keep_e && small_e && err_e);
    check("R4", "ftr_undersized", ftr_undersized, keep_e && small_e && !err_e);
    check("R5", "ftr_error", ftr_error, keep_e && err_e);
    check("R2", "ftr_control", ftr_control, keep_e && ctrl_e);
    check("R7", "pause_go", pause_go, pause_e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R8");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");

    for (int li = 0; li < NLEN; li++) begin
      for (int vi = 0; vi < 512; vi++) begin
        run_frame(LENS[li], 9'(vi));
      end
    end

    // R8: reset wins over a frame that ends while reset is high.
    @(negedge clk);
    frame_len = 16'd100; is_pause = 1; crc_err = 0; align_err = 0; code_err = 0;
    rx_flow_en = 1; copy_ctrl_en = 1; eof_valid = 1; rst = 1;
    @(negedge clk);
    eof_valid = 0; rst = 0;
    check_idle("R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule